// File: doc/BRIEF.md
# Hierarchical Alert Status Aggregator

This block gathers the error flags of a multi-channel temperature and fan monitor into a two-level interrupt structure. It has four sticky lower-level error registers: critical, high-limit, low-limit and diode-fault. Each register latches a bit on any clock in which the matching condition input is true. A top-level status register combines their summaries with level-sensitive fan and GPIO pending inputs. An active-low alert output is driven from the unmasked top-level bits. A separate shutdown output tracks the live critical condition of the channels that are associated with shutdown.

A host reaches the registers through a synchronous strobe interface: an address, a read strobe, a write strobe and write data. Read data is combinational and shows the register value from before any clear. Reading a lower-level register clears only those bits whose condition is no longer present, and the clear takes effect on the following clock edge. The serial host bus, the temperature measurement, the limit comparison and the fan logic all sit outside this block and arrive as condition vectors.

Top module: `alertHub`

## Requirements
- R1: After reset, every status register and the mask register read 00h, `alertN` is 1 and `shutdownOut` is 0.
- R2: A condition input that is true at a clock edge sets its status bit at that edge. Addresses: critical 1Fh, high 24h, low 25h, diode fault 26h. In the high and low registers, bit 0 is the internal channel and bits 1..3 are external channels 1..3. In the diode-fault register, `faultCond[k]` sets bit k+1 and bit 0 always reads 0.
- R3: A set status bit stays set after its condition goes away, until its own register is read.
- R4: A read returns the pre-clear value. At the next edge it clears only the bits whose condition is false in that cycle. When a set and a clear happen together, the set wins, so a persistent condition survives the read.
- R5: The top-level register at 23h holds: bit 5 = any critical bit 3..0, bit 4 = `gpioPend`, bit 3 = `fanPend`, bit 2 = any high bit, bit 1 = any low bit, bit 0 = any diode-fault bit. Reading it clears nothing.
- R6: Critical bit i (bits 0..3) can be set only while `critAssoc[i]` is 1.
- R7: `shutdownOut` is 1 one cycle after any channel has both `critCond` and `critAssoc` set. It drops one cycle after that condition ends, while the latched critical bit stays set.
- R8: The mask register is at 28h. Bit n = 1 masks top-level bit n, and the register is readable. `alertN` is registered: it is 0 one cycle after any unmasked top-level bit is set, and 1 one cycle after none is set.
- R9: `hwShdnCond` sets critical-register bit 7, which is sticky and cleared by the same rule as R4. This bit does not feed top-level bit 5 and never drives `alertN` low.
- R10: Reads of any other address return 00h. A write to any address other than 28h has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register address |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data (combinational) |
| critCond | input | 4 | Live above-critical condition per channel |
| critAssoc | input | 4 | Channel is associated with shutdown |
| highCond | input | 4 | Live above-high-limit condition |
| lowCond | input | 4 | Live below-low-limit condition |
| faultCond | input | 3 | Live diode fault, external channels 1..3 |
| hwShdnCond | input | 1 | Hardware shutdown event |
| fanPend | input | 1 | Fan status summary (level) |
| gpioPend | input | 1 | GPIO status summary (level) |
| alertN | output | 1 | Active-low alert |
| shutdownOut | output | 1 | Shutdown request |

## Verification
The hardest case to reach is a read that hits a register while some of its conditions are still active and others have gone away. The test has to show that only the stale bits clear and that the returned value is the value from before the clear. The stimulus holds one condition across two back-to-back reads, then releases it and reads twice more. This separates persistence from the set-wins rule. Masked alerts need a similar approach. A bit is latched while its mask bit is set, the test checks that the top-level register still reports the bit, and then clears the mask so that `alertN` falls with no new event.

// File: rtl/alertPkg.sv
package alertPkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CRIT,
    SEL_HIGH,
    SEL_LOW,
    SEL_FAULT,
    SEL_TOP,
    SEL_MASK
  } regSelT;

  localparam int NUM_LANES = 4;
  localparam int LANE_CRIT = 0;
  localparam int LANE_HIGH = 1;
  localparam int LANE_LOW = 2;
  localparam int LANE_FAULT = 3;
  localparam int TOP_W = 6;

  typedef struct packed {
    logic [NUM_LANES-1:0] clrErr;
    logic wrMask;
    regSelT sel;
  } ctrlStrobeT;

endpackage

// File: rtl/alertCtrl.sv
module alertCtrl
  import alertPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CRIT_ADDR = 8'h1F,
  parameter logic [ADDR_W-1:0] TOP_ADDR = 8'h23,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] LOW_ADDR = 8'h25,
  parameter logic [ADDR_W-1:0] FAULT_ADDR = 8'h26,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h28
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic regRd,
  input  logic regWr,
  output ctrlStrobeT strb
);

  always_comb begin
    strb = '0;
    strb.sel = SEL_NONE;
    if (regAddr == CRIT_ADDR) begin
      strb.sel = SEL_CRIT;
      strb.clrErr[LANE_CRIT] = regRd;
    end else if (regAddr == HIGH_ADDR) begin
      strb.sel = SEL_HIGH;
      strb.clrErr[LANE_HIGH] = regRd;
    end else if (regAddr == LOW_ADDR) begin
      strb.sel = SEL_LOW;
      strb.clrErr[LANE_LOW] = regRd;
    end else if (regAddr == FAULT_ADDR) begin
      strb.sel = SEL_FAULT;
      strb.clrErr[LANE_FAULT] = regRd;
    end else if (regAddr == TOP_ADDR) begin
      strb.sel = SEL_TOP;
    end else if (regAddr == MASK_ADDR) begin
      strb.sel = SEL_MASK;
      strb.wrMask = regWr;
    end
  end

endmodule

// File: rtl/alertDatapath.sv
module alertDatapath
  import alertPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 4
) (
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobeT strb,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [NUM_CH-1:0] critCond,
  input  logic [NUM_CH-1:0] critAssoc,
  input  logic [NUM_CH-1:0] highCond,
  input  logic [NUM_CH-1:0] lowCond,
  input  logic [NUM_CH-2:0] faultCond,
  input  logic hwShdnCond,
  input  logic fanPend,
  input  logic gpioPend,
  output logic alertN,
  output logic shutdownOut,
  output logic [NUM_CH-1:0] critStat,
  output logic [NUM_CH-1:0] highStat,
  output logic [NUM_CH-1:0] lowStat,
  output logic [NUM_CH-1:0] faultStat,
  output logic hwsStat,
  output logic [TOP_W-1:0] topStat,
  output logic [TOP_W-1:0] maskReg
);

  localparam int HWS_POS = DATA_W - 1;

  logic [NUM_CH-1:0] setVec [NUM_LANES];
  logic [NUM_CH-1:0] errStat [NUM_LANES];
  logic critLive;

  assign critLive = |(critCond & critAssoc);
  assign setVec[LANE_CRIT] = critCond & critAssoc;
  assign setVec[LANE_HIGH] = highCond;
  assign setVec[LANE_LOW] = lowCond;
  assign setVec[LANE_FAULT] = {faultCond, 1'b0};

  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : gLane
    logic [NUM_CH-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneQ <= '0;
      end else if (strb.clrErr[lane]) begin
        laneQ <= setVec[lane];
      end else begin
        laneQ <= laneQ | setVec[lane];
      end
    end
    assign errStat[lane] = laneQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hwsStat <= 1'b0;
    end else if (strb.clrErr[LANE_CRIT]) begin
      hwsStat <= hwShdnCond;
    end else begin
      hwsStat <= hwsStat | hwShdnCond;
    end
  end

  assign critStat = errStat[LANE_CRIT];
  assign highStat = errStat[LANE_HIGH];
  assign lowStat = errStat[LANE_LOW];
  assign faultStat = errStat[LANE_FAULT];

  assign topStat = {|critStat, gpioPend, fanPend, |highStat, |lowStat, |faultStat};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
    end else if (strb.wrMask) begin
      maskReg <= regWdata[TOP_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alertN <= 1'b1;
      shutdownOut <= 1'b0;
    end else begin
      alertN <= ~|(topStat & ~maskReg);
      shutdownOut <= critLive;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (strb.sel)
      SEL_CRIT: begin
        regRdata = DATA_W'(critStat);
        regRdata[HWS_POS] = hwsStat;
      end
      SEL_HIGH: regRdata = DATA_W'(highStat);
      SEL_LOW: regRdata = DATA_W'(lowStat);
      SEL_FAULT: regRdata = DATA_W'(faultStat);
      SEL_TOP: regRdata = DATA_W'(topStat);
      SEL_MASK: regRdata = DATA_W'(maskReg);
      default: regRdata = '0;
    endcase
  end

endmodule

// File: rtl/alertHub.sv
module alertHub
  import alertPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NUM_CH = 4,
  parameter logic [ADDR_W-1:0] CRIT_ADDR = 8'h1F,
  parameter logic [ADDR_W-1:0] TOP_ADDR = 8'h23,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] LOW_ADDR = 8'h25,
  parameter logic [ADDR_W-1:0] FAULT_ADDR = 8'h26,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h28
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic regRd,
  input  logic regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [NUM_CH-1:0] critCond,
  input  logic [NUM_CH-1:0] critAssoc,
  input  logic [NUM_CH-1:0] highCond,
  input  logic [NUM_CH-1:0] lowCond,
  input  logic [NUM_CH-2:0] faultCond,
  input  logic hwShdnCond,
  input  logic fanPend,
  input  logic gpioPend,
  output logic alertN,
  output logic shutdownOut
);

  ctrlStrobeT strb;
  logic [NUM_CH-1:0] critStat;
  logic [NUM_CH-1:0] highStat;
  logic [NUM_CH-1:0] lowStat;
  logic [NUM_CH-1:0] faultStat;
  logic hwsStat;
  logic [TOP_W-1:0] topStat;
  logic [TOP_W-1:0] maskReg;

  alertCtrl #(
    .ADDR_W(ADDR_W), .CRIT_ADDR(CRIT_ADDR), .TOP_ADDR(TOP_ADDR),
    .HIGH_ADDR(HIGH_ADDR), .LOW_ADDR(LOW_ADDR), .FAULT_ADDR(FAULT_ADDR),
    .MASK_ADDR(MASK_ADDR)
  ) ctrl_i (
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .strb(strb)
  );

  alertDatapath #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata),
    .regRdata(regRdata), .critCond(critCond), .critAssoc(critAssoc),
    .highCond(highCond), .lowCond(lowCond), .faultCond(faultCond),
    .hwShdnCond(hwShdnCond), .fanPend(fanPend), .gpioPend(gpioPend),
    .alertN(alertN), .shutdownOut(shutdownOut), .critStat(critStat),
    .highStat(highStat), .lowStat(lowStat), .faultStat(faultStat),
    .hwsStat(hwsStat), .topStat(topStat), .maskReg(maskReg)
  );

endmodule

// File: rtl/alertHubChk.sv
module alertHubChk #(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 4,
  parameter int TOP_W = 6,
  parameter logic [ADDR_W-1:0] TOP_ADDR = 8'h23,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 8'h24
) (
  input logic clk,
  input logic rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic regRd,
  input logic [NUM_CH-1:0] critCond,
  input logic [NUM_CH-1:0] critAssoc,
  input logic [NUM_CH-1:0] lowCond,
  input logic hwShdnCond,
  input logic shutdownOut,
  input logic alertN,
  input logic [NUM_CH-1:0] critStat,
  input logic [NUM_CH-1:0] highStat,
  input logic [NUM_CH-1:0] lowStat,
  input logic hwsStat,
  input logic [TOP_W-1:0] topStat,
  input logic [TOP_W-1:0] maskReg
);

  p_sticky_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (highStat[0] && !(regRd && regAddr == HIGH_ADDR)) |=> highStat[0]);

  p_persist_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    lowCond[1] |=> lowStat[1]);

  p_top_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == TOP_ADDR && highStat != '0) |=> highStat != '0);

  p_assoc_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!critStat[2] && !(critCond[2] && critAssoc[2])) |=> !critStat[2]);

  p_shdn_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|(critCond & critAssoc)) |=> shutdownOut);

  p_shdn_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(|(critCond & critAssoc)) |=> !shutdownOut);

  p_alert_on_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|(topStat & ~maskReg)) |=> !alertN);

  p_alert_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(|(topStat & ~maskReg)) |=> alertN);

  p_hws_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    hwShdnCond |=> hwsStat);

endmodule

bind alertHub alertHubChk #(
  .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .TOP_W(alertPkg::TOP_W),
  .TOP_ADDR(TOP_ADDR), .HIGH_ADDR(HIGH_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRd(regRd),
  .critCond(critCond), .critAssoc(critAssoc), .lowCond(lowCond),
  .hwShdnCond(hwShdnCond), .shutdownOut(shutdownOut), .alertN(alertN),
  .critStat(critStat), .highStat(highStat), .lowStat(lowStat),
  .hwsStat(hwsStat), .topStat(topStat), .maskReg(maskReg)
);

// File: tb/alertHub_tb_top.sv
module alertHub_tb_top;

  localparam logic [7:0] A_CRIT = 8'h1F;
  localparam logic [7:0] A_TOP = 8'h23;
  localparam logic [7:0] A_HIGH = 8'h24;
  localparam logic [7:0] A_LOW = 8'h25;
  localparam logic [7:0] A_FAULT = 8'h26;
  localparam logic [7:0] A_MASK = 8'h28;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regAddr = '0;
  logic regRd = 1'b0;
  logic regWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [3:0] critCond = '0;
  logic [3:0] critAssoc = '0;
  logic [3:0] highCond = '0;
  logic [3:0] lowCond = '0;
  logic [2:0] faultCond = '0;
  logic hwShdnCond = 1'b0;
  logic fanPend = 1'b0;
  logic gpioPend = 1'b0;
  logic alertN;
  logic shutdownOut;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  typedef struct {
    int kind;
    int expVal;
    string tag;
  } expItemT;

  expItemT sbQ[$];

  always #10 clk = ~clk;

  alertHub dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRd(regRd),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata),
    .critCond(critCond), .critAssoc(critAssoc), .highCond(highCond),
    .lowCond(lowCond), .faultCond(faultCond), .hwShdnCond(hwShdnCond),
    .fanPend(fanPend), .gpioPend(gpioPend), .alertN(alertN),
    .shutdownOut(shutdownOut)
  );

  // Monitor: pops expectations pushed at a falling edge, samples 2 ns later.
  always begin
    @(negedge clk);
    #2;
    while (sbQ.size() > 0) begin
      expItemT it;
      int act;
      it = sbQ.pop_front();
      case (it.kind)
        0: act = int'(regRdata);
        1: act = int'(alertN);
        default: act = int'(shutdownOut);
      endcase
      checkCnt++;
      if (act != it.expVal) begin
        failCnt++;
        $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.expVal);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expRd(logic [7:0] addr, int expVal, string tag);
    expItemT it;
    regAddr = addr;
    regRd = 1'b1;
    it.kind = 0; it.expVal = expVal; it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
    regRd = 1'b0;
    regAddr = 8'h00;
  endtask

  task automatic expPin(int kind, int expVal, string tag);
    expItemT it;
    it.kind = kind; it.expVal = expVal; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic wrReg(logic [7:0] addr, logic [7:0] data);
    regAddr = addr;
    regWdata = data;
    regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
    regAddr = 8'h00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    expPin(1, 1, "R1 alertN");
    expPin(2, 0, "R1 shutdownOut");
    expRd(A_CRIT, 8'h00, "R1 crit");
    expRd(A_HIGH, 8'h00, "R1 high");
    expRd(A_TOP, 8'h00, "R1 top");
    expRd(A_MASK, 8'h00, "R1 mask");

    // R2/R3/R5: one-cycle high pulse, sticky, top read clears nothing
    highCond = 4'b0101;
    step(1);
    highCond = 4'b0000;
    step(3);
    expRd(A_TOP, 8'h04, "R5 top high");
    expRd(A_TOP, 8'h04, "R5 top reread");
    expPin(1, 0, "R8 alert low");
    expRd(A_HIGH, 8'h05, "R3 high sticky");
    expRd(A_HIGH, 8'h00, "R4 high cleared");
    step(1);
    expPin(1, 1, "R8 alert released");

    // R4 persistent condition survives reads
    lowCond = 4'b0010;
    step(1);
    expRd(A_LOW, 8'h02, "R4 low first");
    expRd(A_LOW, 8'h02, "R4 low persists");
    lowCond = 4'b0000;
    expRd(A_LOW, 8'h02, "R4 low pre-clear value");
    expRd(A_LOW, 8'h00, "R4 low cleared");

    // R2 diode-fault layout
    faultCond = 3'b111;
    step(1);
    faultCond = 3'b000;
    expRd(A_FAULT, 8'h0E, "R2 fault layout");
    expRd(A_FAULT, 8'h00, "R4 fault cleared");

    // R6/R7 critical association and shutdown
    critAssoc = 4'b0011;
    critCond = 4'b1111;
    step(1);
    expPin(2, 1, "R7 shutdown asserted");
    expRd(A_CRIT, 8'h03, "R6 assoc gating");
    expRd(A_TOP, 8'h20, "R5 top crit");
    critCond = 4'b0000;
    step(1);
    expPin(2, 0, "R7 shutdown released");
    expRd(A_CRIT, 8'h03, "R7 crit stays latched");
    expRd(A_CRIT, 8'h00, "R4 crit cleared");
    critAssoc = 4'b0000;
    step(2);

    // R9 hardware-shutdown bit
    hwShdnCond = 1'b1;
    step(1);
    hwShdnCond = 1'b0;
    step(2);
    expPin(1, 1, "R9 no alert from HWS");
    expRd(A_TOP, 8'h00, "R9 top unaffected");
    expRd(A_CRIT, 8'h80, "R9 hws bit7");
    expRd(A_CRIT, 8'h00, "R9 hws cleared");

    // R8 masking
    wrReg(A_MASK, 8'h04);
    expRd(A_MASK, 8'h04, "R8 mask readback");
    highCond = 4'b0001;
    step(1);
    highCond = 4'b0000;
    step(1);
    expPin(1, 1, "R8 masked alert");
    expRd(A_TOP, 8'h04, "R8 top still reports");
    wrReg(A_MASK, 8'h00);
    step(1);
    expPin(1, 0, "R8 unmasked alert");
    expRd(A_HIGH, 8'h01, "R8 high value");
    step(1);
    expPin(1, 1, "R8 alert after clear");

    // R5 fan and gpio summaries
    fanPend = 1'b1;
    step(1);
    expPin(1, 0, "R8 fan alert");
    expRd(A_TOP, 8'h08, "R5 fan bit");
    fanPend = 1'b0;
    gpioPend = 1'b1;
    expRd(A_TOP, 8'h10, "R5 gpio bit");
    gpioPend = 1'b0;
    step(2);
    expPin(1, 1, "R5 summaries gone");

    // R10 other addresses
    expRd(8'h30, 8'h00, "R10 unused address");
    wrReg(A_HIGH, 8'hFF);
    step(1);
    expRd(A_HIGH, 8'h00, "R10 write ignored");

    step(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule